// File: doc/BRIEF.md
# Single-Clock Streaming FIFO Link with Sideband Control Bit

This block is a one-way stream link between a producer (master side) and a consumer (slave side) that share one clock. Each word has a data field and one sideband control bit that travels with it. The producer pushes words while `m_full` is low. The consumer sees the oldest word on `s_data`/`s_ctrl` whenever `s_exists` is high, and it pops that word with `s_rd`.

The depth is set by `DEPTH`. `CTRL_EN` chooses whether the control bit is stored and forwarded. When it is off, no storage is spent on the bit and the consumer always reads 0. `BLOCK_STYLE` chooses the storage style. The register-array style presents the head word combinationally, so a word is visible right after it is written. The block-memory style uses a registered read port. Because of that, a word that becomes the head in the same edge it is written shows up one cycle later.

Top module: `stream_link_fifo`

## Requirements
- R1: While reset is held and after it is released with no traffic, `s_exists` and `m_full` are both low.
- R2: With `CTRL_EN`=1, words are delivered in write order, each with the control bit that was written alongside it on `m_ctrl`.
- R3: With `CTRL_EN`=0, `s_ctrl` reads 0 at all times, whatever is driven on `m_ctrl`.
- R4: `m_full` goes high on the edge that brings the occupancy to `DEPTH`. A write while `m_full` is high is dropped and never appears at the slave side.
- R5: A read while `s_exists` is low has no effect. The link stays empty, and a later write is delivered normally.
- R6: A read and a write in the same cycle on a partly filled link leave the occupancy unchanged. This is observable because `m_full` rises only after as many further writes as before.
- R7: With `BLOCK_STYLE`=0, a write into an empty link raises `s_exists` right after that write's clock edge, and `s_data` shows the word at the same time.
- R8: With `BLOCK_STYLE`=1, a write into an empty link raises `s_exists` one clock edge later than with `BLOCK_STYLE`=0, and then shows the word.
- R9: With `BLOCK_STYLE`=1 and exactly one word stored, a read and a write in the same cycle drop `s_exists` for one cycle. After that cycle the new word is shown.
- R10: `DEPTH` is accepted from 1 to 8192 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_wr | input | 1 | Producer write strobe |
| m_data | input | DATA_W | Producer data word |
| m_ctrl | input | 1 | Producer sideband control bit |
| m_full | output | 1 | Link holds DEPTH words |
| s_rd | input | 1 | Consumer pop strobe |
| s_data | output | DATA_W | Head data word |
| s_ctrl | output | 1 | Head control bit (0 when CTRL_EN=0) |
| s_exists | output | 1 | A head word is available |

## Verification
In register-array style, `s_exists`, `s_data` and `m_full` change on the same edge that captures a write. In block-memory style, a word that becomes the head during that edge appears one edge later. A pop shows the next word right after its own edge in both styles. The bench drives inputs on the falling edge and checks on the next falling edge, half a period after the capturing edge. For the block-memory delay it waits exactly one extra falling edge and checks that `s_exists` is low first and high afterwards.

// File: rtl/stream_link_fifo.sv
module stream_link_fifo #(
  parameter int DATA_W      = 32,
  parameter int DEPTH       = 16,
  parameter bit CTRL_EN     = 1'b1,
  parameter bit BLOCK_STYLE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              m_wr,
  input  logic [DATA_W-1:0] m_data,
  input  logic              m_ctrl,
  output logic              m_full,
  input  logic              s_rd,
  output logic [DATA_W-1:0] s_data,
  output logic              s_ctrl,
  output logic              s_exists
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int WW = DATA_W + int'(CTRL_EN);

  logic [WW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, rd_ptr_nx;
  logic [CW-1:0] count;
  logic [WW-1:0] wr_word, head_word;
  logic          do_wr, do_rd, head_rdy;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign m_full    = (count == CW'(DEPTH));
  assign s_exists  = (count != '0) && head_rdy;
  assign do_wr     = m_wr && !m_full;
  assign do_rd     = s_rd && s_exists;
  assign rd_ptr_nx = do_rd ? bump(rd_ptr) : rd_ptr;
  assign s_data    = head_word[DATA_W-1:0];

  generate
    if (CTRL_EN) begin : g_ctrl
      assign wr_word = {m_ctrl, m_data};
      assign s_ctrl  = head_word[WW-1];
    end else begin : g_no_ctrl
      assign wr_word = m_data;
      assign s_ctrl  = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk)
    if (do_wr) mem[wr_ptr] <= wr_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_wr) wr_ptr <= bump(wr_ptr);
      rd_ptr <= rd_ptr_nx;
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  generate
    if (BLOCK_STYLE) begin : g_block
      logic [WW-1:0] rd_q;
      logic          hide;
      always_ff @(posedge clk)
        rd_q <= mem[rd_ptr_nx];
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) hide <= 1'b0;
        else        hide <= do_wr && ((count - CW'(do_rd)) == '0);
      assign head_word = rd_q;
      assign head_rdy  = !hide;
    end else begin : g_lut
      assign head_word = mem[rd_ptr];
      assign head_rdy  = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/stream_link_fifo_chk.sv
module stream_link_fifo_chk #(
  parameter int DEPTH       = 16,
  parameter bit CTRL_EN     = 1'b1,
  parameter bit BLOCK_STYLE = 1'b0,
  parameter int CW          = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          m_wr,
  input logic          m_full,
  input logic          s_rd,
  input logic          s_exists,
  input logic          s_ctrl,
  input logic [CW-1:0] count
);
  initial assert_depth_range_R10: assert (DEPTH >= 1 && DEPTH <= 8192);

  assert_reset_empty_R1: assert property (@(posedge clk)
    !rst_n |-> (!s_exists && !m_full));

  assert_ctrl_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !CTRL_EN |-> !s_ctrl);

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_full && !(s_rd && s_exists)) |=> (m_full && $stable(count)));

  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && !m_wr) |=> (count == '0 && !s_exists));

  assert_occupancy_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_wr && !m_full && s_rd && s_exists) |=> $stable(count));

  assert_fall_through_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!BLOCK_STYLE && count == '0 && m_wr) |=> s_exists);

  assert_block_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (BLOCK_STYLE && count == '0 && m_wr) |=> (!s_exists ##1 s_exists));

  assert_block_refill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (BLOCK_STYLE && count == CW'(1) && s_exists && s_rd && m_wr) |=> !s_exists);
endmodule

bind stream_link_fifo stream_link_fifo_chk #(
  .DEPTH(DEPTH), .CTRL_EN(CTRL_EN), .BLOCK_STYLE(BLOCK_STYLE), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .m_wr(m_wr), .m_full(m_full), .s_rd(s_rd),
  .s_exists(s_exists), .s_ctrl(s_ctrl), .count(count)
);

// File: tb/test_stream_link_fifo.sv
module test_stream_link_fifo;
  localparam int DW = 16;
  localparam int DP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          a_wr = 0, a_ctrl = 0, a_rd = 0, a_full, a_exists, a_sctrl;
  logic [DW-1:0] a_data = '0, a_sdata;
  logic          b_wr = 0, b_ctrl = 0, b_rd = 0, b_full, b_exists, b_sctrl;
  logic [DW-1:0] b_data = '0, b_sdata;

  int n_run = 0, n_fail = 0;

  stream_link_fifo #(.DATA_W(DW), .DEPTH(DP), .CTRL_EN(1'b1), .BLOCK_STYLE(1'b0)) i_stream_link_fifo (
    .clk(clk), .rst_n(rst_n), .m_wr(a_wr), .m_data(a_data), .m_ctrl(a_ctrl), .m_full(a_full),
    .s_rd(a_rd), .s_data(a_sdata), .s_ctrl(a_sctrl), .s_exists(a_exists));

  stream_link_fifo #(.DATA_W(DW), .DEPTH(DP), .CTRL_EN(1'b0), .BLOCK_STYLE(1'b1)) i_stream_link_fifo_blk (
    .clk(clk), .rst_n(rst_n), .m_wr(b_wr), .m_data(b_data), .m_ctrl(b_ctrl), .m_full(b_full),
    .s_rd(b_rd), .s_data(b_sdata), .s_ctrl(b_sctrl), .s_exists(b_exists));

  task automatic chk(input string req, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic push_a(input logic [DW-1:0] d, input logic c);
    a_wr = 1; a_data = d; a_ctrl = c; step(); a_wr = 0;
  endtask

  task automatic pop_a(input string req, input logic [DW-1:0] d, input logic c);
    chk({req, " exists"}, a_exists, 1);
    chk({req, " data"}, a_sdata, d);
    chk({req, " ctrl"}, a_sctrl, c);
    a_rd = 1; step(); a_rd = 0;
  endtask

  task automatic push_b(input logic [DW-1:0] d);
    b_wr = 1; b_data = d; b_ctrl = 1; step(); b_wr = 0;
  endtask

  task automatic t_reset();
    chk("R1 exists a", a_exists, 0); chk("R1 full a", a_full, 0);
    chk("R1 exists b", b_exists, 0); chk("R1 full b", b_full, 0);
    rst_n = 1; step();
    chk("R1 exists after release", a_exists, 0);
    chk("R1 full after release", b_full, 0);
  endtask

  task automatic t_order();
    push_a(16'h1111, 1);
    chk("R7 exists after write", a_exists, 1);
    chk("R7 data after write", a_sdata, 16'h1111);
    push_a(16'h2222, 0);
    push_a(16'h3333, 1);
    pop_a("R2 w0", 16'h1111, 1);
    pop_a("R2 w1", 16'h2222, 0);
    pop_a("R2 w2", 16'h3333, 1);
    chk("R2 empty after drain", a_exists, 0);
  endtask

  task automatic t_full();
    for (int i = 0; i < DP; i++) begin
      chk("R4 not full yet", a_full, 0);
      push_a(DW'(16'hA0 + i), i[0]);
    end
    chk("R4 full at depth", a_full, 1);
    push_a(16'hDEAD, 1);
    chk("R4 still full", a_full, 1);
    for (int i = 0; i < DP; i++) pop_a("R4 drain", DW'(16'hA0 + i), i[0]);
    chk("R4 dropped word absent", a_exists, 0);
  endtask

  task automatic t_empty_read();
    a_rd = 1; step(); step(); step(); a_rd = 0;
    chk("R5 still empty", a_exists, 0);
    chk("R5 not full", a_full, 0);
    push_a(16'h0055, 0);
    pop_a("R5 later write", 16'h0055, 0);
    chk("R5 empty again", a_exists, 0);
  endtask

  task automatic t_simul();
    push_a(16'h0101, 0);
    push_a(16'h0202, 1);
    a_rd = 1; a_wr = 1; a_data = 16'h0303; a_ctrl = 0; step(); a_rd = 0; a_wr = 0;
    chk("R6 head advanced", a_sdata, 16'h0202);
    push_a(16'h0404, 1);
    chk("R6 not full at three", a_full, 0);
    push_a(16'h0505, 0);
    chk("R6 full at four", a_full, 1);
    pop_a("R6 d0", 16'h0202, 1);
    pop_a("R6 d1", 16'h0303, 0);
    pop_a("R6 d2", 16'h0404, 1);
    pop_a("R6 d3", 16'h0505, 0);
    chk("R6 empty", a_exists, 0);
  endtask

  task automatic t_block();
    push_b(16'h00AB);
    chk("R8 exists held low", b_exists, 0);
    step();
    chk("R8 exists one edge later", b_exists, 1);
    chk("R8 data", b_sdata, 16'h00AB);
    chk("R3 ctrl forced zero", b_sctrl, 0);
    push_b(16'h00CD);
    chk("R8 head unchanged", b_sdata, 16'h00AB);
    b_rd = 1; step(); b_rd = 0;
    chk("R8 next word exists", b_exists, 1);
    chk("R8 next word data", b_sdata, 16'h00CD);
    chk("R3 ctrl zero second word", b_sctrl, 0);
    b_rd = 1; step(); b_rd = 0;
    chk("R8 drained", b_exists, 0);
  endtask

  task automatic t_block_refill();
    push_b(16'h0011); step();
    chk("R9 first word", b_sdata, 16'h0011);
    b_rd = 1; b_wr = 1; b_data = 16'h0022; step(); b_rd = 0; b_wr = 0;
    chk("R9 exists dips", b_exists, 0);
    step();
    chk("R9 exists back", b_exists, 1);
    chk("R9 new word", b_sdata, 16'h0022);
    b_rd = 1; step(); b_rd = 0;
    chk("R9 drained", b_exists, 0);
  endtask

  initial begin
    step(); step();
    t_reset();
    t_order();
    t_full();
    t_empty_read();
    t_simul();
    t_block();
    t_block_refill();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule